// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block sits between instruction decode and the data memory port of a simple core and handles one single-register load or store per request. From a base register value, an offset and five addressing-mode bits, it computes the memory address, the base-register writeback value and its enable, the byte enables and the lane-aligned store data. The offset comes from a 12-bit immediate, from an already shifted register value, or from an 8-bit immediate split into two 4-bit fields.

The memory port is a plain one-cycle request/response. The request outputs are combinational and are valid in the same cycle as `req_valid_i`. The read data returns with `mem_rvalid_i` in the next cycle. The block then extracts the addressed byte or halfword, zero- or sign-extends it, and presents the result from a register one cycle later. The shifter and the register file are outside the block.

Top module: `ls_fmt`

## Requirements
- R1: `mode_i` bit positions are: bit 0 = load (1) / store (0), bit 1 = writeback, bit 2 = byte, bit 3 = up, bit 4 = pre-index. `mem_req_o` follows `req_valid_i`, and `mem_we_o` is high only for a valid store.
- R2: Post-index (bit 4 = 0): `mem_addr_o` equals `base_i`, and `wb_en_o` is set whether or not the writeback bit is set.
- R3: Pre-index (bit 4 = 1): `mem_addr_o` equals base ± offset. `wb_en_o` is set only when the writeback bit is 1.
- R4: `wb_val_o` always carries base + offset when the up bit is 1 and base − offset when it is 0, with modulo 2^32 wrap.
- R5: Offset source `off_sel_i`: 0 = `imm_i` zero-extended, 1 = `shreg_i`, 2 = `{imm_hi_i, imm_lo_i}` as an 8-bit value zero-extended, 3 = zero.
- R6: Transfer size: when `hclass_i` = 0, mode bit 2 selects byte (1) or word (0). When `hclass_i` = 1, `hkind_i` selects the size: 2'b10 = signed byte, 2'b11 = signed halfword, 2'b01 or 2'b00 = unsigned halfword. Mode bit 2 is ignored in this case.
- R7: Byte enables are little-endian. A word enables 4'b1111. A halfword enables 4'b0011 shifted left by 2·addr[1]. A byte enables 4'b0001 shifted left by addr[1:0].
- R8: Store data: a word store passes `st_data_i` through unchanged, a halfword store repeats bits [15:0] in both halves, and a byte store repeats bits [7:0] in all four lanes.
- R9: A word load returns the full word. An unsigned byte load returns the byte at lane addr[1:0] zero-extended.
- R10: Halfword loads take bits [16·addr[1] +: 16]. Unsigned halfword loads zero-extend. Signed byte loads sign-extend from bit 7 and signed halfword loads sign-extend from bit 15.
- R11: When a load's `dst_idx_i` equals `base_idx_i`, `wb_en_o` is 0. A store with equal indices still writes back.
- R12: `ld_valid_o` rises exactly one cycle after a cycle with `mem_rvalid_i` high. `ld_data_o` holds its value in all other cycles.
- R13: After reset, `ld_valid_o` and `ld_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| mode_i | input | 5 | {pre, up, byte, writeback, load} |
| hclass_i | input | 1 | Halfword/signed transfer class |
| hkind_i | input | 2 | Kind within the halfword class |
| off_sel_i | input | 2 | Offset source select |
| imm_i | input | 12 | 12-bit immediate offset |
| shreg_i | input | 32 | Shifted register offset |
| imm_hi_i | input | 4 | High nibble of split immediate |
| imm_lo_i | input | 4 | Low nibble of split immediate |
| base_i | input | 32 | Base register value |
| base_idx_i | input | 4 | Base register index |
| dst_idx_i | input | 4 | Data register index |
| st_data_i | input | 32 | Store source value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 32 | Base writeback value |
| ld_valid_o | output | 1 | Formatted load result valid |
| ld_data_o | output | 32 | Formatted load result |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 12-bit immediate and 4-bit register indices. These sizes let it sweep all 32 mode codes against all four offset sources, with operands chosen to force wrap in both directions. They also keep the full 16×16 grid of register-index pairs small enough to cover for the base-conflict rule. Every transfer kind is run at every lane offset, with read words whose top bits are set in each lane, so both the sign-extension and zero-extension paths are exercised.

// File: rtl/ls_fmt_pkg.sv
package ls_fmt_pkg;
  typedef enum logic [1:0] {
    OFF_IMM   = 2'd0,
    OFF_SHREG = 2'd1,
    OFF_SPLIT = 2'd2,
    OFF_ZERO  = 2'd3
  } off_sel_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } size_e;

  // bit order matters: load is bit 0, pre-index bit 4
  typedef struct packed {
    logic pre;
    logic up;
    logic byte_b;
    logic wback;
    logic load;
  } mode_t;
endpackage

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int NIB_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic              req_i,
  input  mode_t             mode_i,
  input  off_sel_e          off_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] shreg_i,
  input  logic [NIB_W-1:0]  imm_hi_i,
  input  logic [NIB_W-1:0]  imm_lo_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  output logic [DATA_W-1:0] addr_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_val_o
);
  logic [DATA_W-1:0] offset, signed_off, sum;
  logic              same_reg;

  always_comb begin
    unique case (off_sel_i)
      OFF_IMM:   offset = DATA_W'(imm_i);
      OFF_SHREG: offset = shreg_i;
      OFF_SPLIT: offset = DATA_W'({imm_hi_i, imm_lo_i});
      default:   offset = '0;
    endcase
  end

  // negate once, share a single adder
  assign signed_off = mode_i.up ? offset : (~offset + DATA_W'(1));
  assign sum        = base_i + signed_off;
  assign same_reg   = mode_i.load && (dst_idx_i == base_idx_i);

  assign addr_o   = mode_i.pre ? sum : base_i;
  assign wb_val_o = sum;
  assign wb_en_o  = req_i && (!mode_i.pre || mode_i.wback) && !same_reg;
endmodule

// File: rtl/ls_store_lane.sv
module ls_store_lane
  import ls_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NLANES = DATA_W / 8,
  localparam int LANE_W = $clog2(NLANES)
) (
  input  size_e             size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [NLANES-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o
);
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic       lane_be;
    logic [7:0] lane_byte;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          lane_be   = (lane_i == LANE_W'(i));
          lane_byte = src_i[7:0];
        end
        SZ_HALF: begin
          lane_be   = (lane_i[LANE_W-1:1] == (LANE_W-1)'(i / 2));
          lane_byte = src_i[8*(i%2) +: 8];
        end
        default: begin
          lane_be   = 1'b1;
          lane_byte = src_i[8*i +: 8];
        end
      endcase
    end
    assign be_o[i]           = lane_be;
    assign wdata_o[8*i +: 8] = lane_byte;
  end
endmodule

// File: rtl/ls_load_fmt.sv
module ls_load_fmt
  import ls_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NLANES = DATA_W / 8,
  localparam int LANE_W = $clog2(NLANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  size_e             size_i,
  input  logic              sext_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o
);
  size_e             ctx_size;
  logic              ctx_sext;
  logic [LANE_W-1:0] ctx_lane;
  logic [7:0]        sel_byte;
  logic [15:0]       sel_half;
  logic [DATA_W-1:0] fmt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_size <= SZ_WORD;
      ctx_sext <= 1'b0;
      ctx_lane <= '0;
    end else if (capture_i) begin
      ctx_size <= size_i;
      ctx_sext <= sext_i;
      ctx_lane <= lane_i;
    end
  end

  assign sel_byte = rdata_i[{ctx_lane, 3'b000} +: 8];
  assign sel_half = rdata_i[{ctx_lane[LANE_W-1:1], 4'b0000} +: 16];

  always_comb begin
    unique case (ctx_size)
      SZ_BYTE: fmt = ctx_sext ? DATA_W'($signed(sel_byte)) : DATA_W'(sel_byte);
      SZ_HALF: fmt = ctx_sext ? DATA_W'($signed(sel_half)) : DATA_W'(sel_half);
      default: fmt = rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= rvalid_i;
      if (rvalid_i) ld_data_o <= fmt;
    end
  end

  p_ld_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |=> ld_valid_o);
  p_ld_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_i |=> (!ld_valid_o && $stable(ld_data_o)));
endmodule

// File: rtl/ls_fmt.sv
module ls_fmt
  import ls_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int NIB_W  = 4,
  parameter int IDX_W  = 4,
  localparam int NLANES = DATA_W / 8,
  localparam int LANE_W = $clog2(NLANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [4:0]        mode_i,
  input  logic              hclass_i,
  input  logic [1:0]        hkind_i,
  input  logic [1:0]        off_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] shreg_i,
  input  logic [NIB_W-1:0]  imm_hi_i,
  input  logic [NIB_W-1:0]  imm_lo_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [NLANES-1:0] mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_val_o,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o
);
  mode_t mode;
  size_e size;
  logic  sext;

  assign mode = mode_t'(mode_i);

  always_comb begin
    if (hclass_i) size = (hkind_i == 2'b10) ? SZ_BYTE : SZ_HALF;
    else          size = mode.byte_b ? SZ_BYTE : SZ_WORD;
  end
  assign sext = hclass_i && hkind_i[1];

  assign mem_req_o = req_valid_i;
  assign mem_we_o  = req_valid_i && !mode.load;

  ls_addr_gen #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .NIB_W(NIB_W), .IDX_W(IDX_W)
  ) u_addr (
    .req_i      (req_valid_i),
    .mode_i     (mode),
    .off_sel_i  (off_sel_e'(off_sel_i)),
    .imm_i      (imm_i),
    .shreg_i    (shreg_i),
    .imm_hi_i   (imm_hi_i),
    .imm_lo_i   (imm_lo_i),
    .base_i     (base_i),
    .base_idx_i (base_idx_i),
    .dst_idx_i  (dst_idx_i),
    .addr_o     (mem_addr_o),
    .wb_en_o    (wb_en_o),
    .wb_val_o   (wb_val_o)
  );

  ls_store_lane #(.DATA_W(DATA_W)) u_st (
    .size_i  (size),
    .lane_i  (mem_addr_o[LANE_W-1:0]),
    .src_i   (st_data_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  ls_load_fmt #(.DATA_W(DATA_W)) u_ld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (req_valid_i && mode.load),
    .size_i     (size),
    .sext_i     (sext),
    .lane_i     (mem_addr_o[LANE_W-1:0]),
    .rvalid_i   (mem_rvalid_i),
    .rdata_i    (mem_rdata_i),
    .ld_valid_o (ld_valid_o),
    .ld_data_o  (ld_data_o)
  );

  p_load_no_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode.load) |-> !mem_we_o);
  p_post_wb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mode.pre && !(mode.load && dst_idx_i == base_idx_i)) |-> wb_en_o);
  p_pre_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode.pre) |-> (mem_addr_o == wb_val_o));
  p_be_shape_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                     $countones(mem_be_o) == NLANES));
  p_base_conflict_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode.load && dst_idx_i == base_idx_i) |-> !wb_en_o);
endmodule

// File: tb/ls_fmt_test.sv
module ls_fmt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [4:0]  mode_i = '0;
  logic        hclass_i = 1'b0;
  logic [1:0]  hkind_i = '0;
  logic [1:0]  off_sel_i = '0;
  logic [11:0] imm_i = '0;
  logic [31:0] shreg_i = '0;
  logic [3:0]  imm_hi_i = '0, imm_lo_i = '0;
  logic [31:0] base_i = '0;
  logic [3:0]  base_idx_i = '0, dst_idx_i = '0;
  logic [31:0] st_data_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        wb_en_o;
  logic [31:0] wb_val_o;
  logic        ld_valid_o;
  logic [31:0] ld_data_o;

  int checks = 0, errors = 0;
  bit done = 0;

  ls_fmt uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_off(input logic [1:0] sel);
    case (sel)
      2'd0: return {20'h0, imm_i};
      2'd1: return shreg_i;
      2'd2: return {24'h0, imm_hi_i, imm_lo_i};
      default: return 32'h0;
    endcase
  endfunction

  // kind: 0 word, 1 ubyte, 2 uhalf, 3 sbyte, 4 shalf
  task automatic set_kind(input int k);
    hclass_i = (k >= 2);
    mode_i[2] = (k == 1);
    hkind_i = (k == 2) ? 2'b01 : (k == 3) ? 2'b10 : (k == 4) ? 2'b11 : 2'b00;
  endtask

  function automatic logic [31:0] exp_ld(input int k, input logic [1:0] ln, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*ln +: 8];
    h = w[16*ln[1] +: 16];
    case (k)
      0: return w;
      1: return {24'h0, b};
      2: return {16'h0, h};
      3: return {{24{b[7]}}, b};
      default: return {{16{h[15]}}, h};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] off, sum, held;
    repeat (3) @(negedge clk_i);
    #1;
    // R13 reset state
    chk(ld_valid_o == 1'b0, "R13 ld_valid", {31'h0, ld_valid_o}, 32'h0);
    chk(ld_data_o == 32'h0, "R13 ld_data", ld_data_o, 32'h0);
    rst_ni = 1'b1;

    // R1..R5 address/writeback sweep
    imm_i = 12'hABC; shreg_i = 32'h8000_0123; imm_hi_i = 4'h7; imm_lo_i = 4'hE;
    dst_idx_i = 4'd1; base_idx_i = 4'd2;
    for (int bsel = 0; bsel < 2; bsel++) begin
      for (int m = 0; m < 32; m++) begin
        for (int s = 0; s < 4; s++) begin
          @(negedge clk_i);
          base_i = bsel ? 32'h0000_0004 : 32'hFFFF_FF00;
          mode_i = m[4:0]; off_sel_i = s[1:0]; hclass_i = 1'b0; req_valid_i = 1'b1;
          #1;
          off = exp_off(s[1:0]);
          sum = mode_i[3] ? base_i + off : base_i - off;
          chk(wb_val_o == sum, "R4 R5 wb_val", wb_val_o, sum);
          chk(mem_addr_o == (mode_i[4] ? sum : base_i), "R2 R3 addr", mem_addr_o,
              mode_i[4] ? sum : base_i);
          chk(wb_en_o == (!mode_i[4] || mode_i[1]), "R2 R3 wb_en", {31'h0, wb_en_o},
              {31'h0, (!mode_i[4] || mode_i[1])});
          chk(mem_we_o == !mode_i[0] && mem_req_o, "R1 we/req", {30'h0, mem_req_o, mem_we_o},
              {30'h0, 1'b1, !mode_i[0]});
        end
      end
    end

    // R11 base conflict grid
    off_sel_i = 2'd3;
    for (int d = 0; d < 16; d++) begin
      for (int b = 0; b < 16; b++) begin
        for (int ld = 0; ld < 2; ld++) begin
          @(negedge clk_i);
          dst_idx_i = d[3:0]; base_idx_i = b[3:0]; mode_i = {4'b0000, ld[0]};
          #1;
          chk(wb_en_o == !(ld == 1 && d == b), "R11 conflict", {31'h0, wb_en_o},
              {31'h0, !(ld == 1 && d == b)});
        end
      end
    end

    // R6..R8 store lanes
    dst_idx_i = 4'd1; base_idx_i = 4'd2; st_data_i = 32'hA1B2_C3D4;
    for (int k = 0; k < 5; k++) begin
      for (int ln = 0; ln < 4; ln++) begin
        logic [3:0]  ebe;
        logic [31:0] ewd;
        @(negedge clk_i);
        mode_i = 5'b00000; set_kind(k);
        if (k >= 2) mode_i[2] = 1'b1;   // R6 byte bit ignored in halfword class
        base_i = 32'h0000_1000 | ln;
        #1;
        if (k == 0) begin ebe = 4'hF; ewd = st_data_i; end
        else if (k == 1 || k == 3) begin ebe = 4'h1 << ln; ewd = {4{st_data_i[7:0]}}; end
        else begin ebe = 4'h3 << (2 * (ln / 2)); ewd = {2{st_data_i[15:0]}}; end
        chk(mem_be_o == ebe, "R6 R7 be", {28'h0, mem_be_o}, {28'h0, ebe});
        chk(mem_wdata_o == ewd, "R8 wdata", mem_wdata_o, ewd);
      end
    end

    // R9 R10 R12 load formatting
    for (int v = 0; v < 2; v++) begin
      for (int k = 0; k < 5; k++) begin
        for (int ln = 0; ln < 4; ln++) begin
          logic [31:0] w, e;
          w = v ? 32'h1234_F687 : 32'h80FF_7F01;
          @(negedge clk_i);
          req_valid_i = 1'b1; mode_i = 5'b00001; set_kind(k);
          base_i = 32'h0000_2000 | ln;
          @(negedge clk_i);
          req_valid_i = 1'b0; mem_rvalid_i = 1'b1; mem_rdata_i = w;
          #1;
          chk(ld_valid_o == 1'b0, "R12 not early", {31'h0, ld_valid_o}, 32'h0);
          @(negedge clk_i);
          mem_rvalid_i = 1'b0; mem_rdata_i = ~w;
          #1;
          e = exp_ld(k, ln[1:0], w);
          chk(ld_valid_o == 1'b1, "R12 valid", {31'h0, ld_valid_o}, 32'h1);
          chk(ld_data_o == e, (k < 2) ? "R9 load data" : "R10 load data", ld_data_o, e);
          held = ld_data_o;
          @(negedge clk_i);
          #1;
          chk(ld_valid_o == 1'b0, "R12 pulse", {31'h0, ld_valid_o}, 32'h0);
          chk(ld_data_o == held, "R12 hold", ld_data_o, held);
          req_valid_i = 1'b1;
        end
      end
    end
    req_valid_i = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule